// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a digitised "supply below threshold" flag from an external comparator into an active-low power-on reset for the rest of the chip. The flag is asynchronous, so it first passes through a synchroniser. While the supply is low the reset stays asserted. Once the supply recovers, a hold counter keeps reset asserted for a fixed time before releasing it. That time is nominally 40 ms, given in clock cycles.

After release, a qualification counter filters out short dips. The supply has to stay low for more than a programmable number of cycles before reset is asserted again; shorter dips leave the output high. The block runs on a free-running clock. Its synchronous reset puts it in the asserted state, so the output is low from the first clock edge.

Top module: `supply_rst_seq`

## Requirements
- R1: Once the output has dropped, `por_n` stays 0 for as long as `supply_low_a` stays 1.
- R2: When `supply_low_a` goes from 1 to 0 while `por_n` is 0, `por_n` rises exactly SYNC_STAGES+1+HOLD_CYCLES rising edges later, provided the flag stays 0 for that time.
- R3: After `rst`, `por_n` is 0 and stays 0 while `supply_low_a` is 1. Release then follows the R2 timing.
- R4: If `supply_low_a` rises while `por_n` is 1 and stays 1 for more than QUAL_CYCLES cycles, `por_n` falls exactly SYNC_STAGES+1+QUAL_CYCLES edges after the rise.
- R5: A high pulse on `supply_low_a` lasting QUAL_CYCLES cycles or fewer while `por_n` is 1 leaves `por_n` at 1.
- R6: While `por_n` is 1 and `supply_low_a` stays 0, `por_n` stays 1.
- R7: A return of `supply_low_a` to 1 during the hold time clears the hold count. The hold time is measured again, from zero, after the flag next returns to 0.
- R8: The qualification count clears whenever the synchronised flag is seen at 0 for a single cycle, so separate short dips never add up to a reset.
- R9: `rst` (active high, synchronous) forces `por_n` to 0 at the next edge and restarts the sequence as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_low_a | input | 1 | Asynchronous comparator flag, 1 = supply below threshold |
| por_n | output | 1 | Active-low power-on reset, registered |

## Verification
Every result lags its stimulus by a fixed number of edges: SYNC_STAGES edges through the synchroniser, one edge for the state update, and then HOLD_CYCLES or QUAL_CYCLES edges for the counter involved. In the bench a release is due at HOLD_CYCLES+3 edges and a trip at QUAL_CYCLES+3 edges. A reset takes effect one edge after `rst` is sampled. The driver logs each expected value against the absolute cycle in which it is due. Each release and trip is checked on both sides of the edge on which it is due. The monitor compares `por_n` only on the falling clock edge of that exact cycle, and it reports any entry whose cycle has passed without a comparison.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } srs_state_e;

    function automatic int unsigned us_to_cycles(input int unsigned hz, input int unsigned us);
        longint unsigned prod;
        prod = (longint'(hz) * longint'(us)) / 64'd1_000_000;
        if (prod < 64'd1) prod = 64'd1;
        return int'(prod);
    endfunction

    function automatic int unsigned cnt_width(input int unsigned max_val);
        int unsigned w;
        w = $clog2(max_val + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] st;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[i] <= 1'b1;
                else     st[i] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[i] <= 1'b1;
                else     st[i] <= st[i-1];
            end
        end
    end

    assign q_sync = st[STAGES-1];
endmodule

// File: rtl/srs_qual.sv
module srs_qual import srs_pkg::*; #(
    parameter int unsigned QUAL_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic low,
    output logic trip
);
    localparam int unsigned QW = cnt_width(QUAL_CYCLES);
    localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES);

    logic [QW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm || !low) cnt <= '0;
        else if (cnt != QMAX)    cnt <= cnt + 1'b1;
    end

    assign trip = arm && low && (cnt == QMAX);
endmodule

// File: rtl/srs_hold.sv
module srs_hold import srs_pkg::*; #(
    parameter int unsigned HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic low,
    output logic done
);
    localparam int unsigned HW = cnt_width(HOLD_CYCLES);
    localparam logic [HW-1:0] HLAST = HW'(HOLD_CYCLES - 1);

    logic [HW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || low) cnt <= '0;
        else if (cnt != HLAST)  cnt <= cnt + 1'b1;
    end

    assign done = run && !low && (cnt == HLAST);
endmodule

// File: rtl/supply_rst_seq.sv
module supply_rst_seq import srs_pkg::*; #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned HOLD_CYCLES = us_to_cycles(CLK_HZ, 40_000),
    parameter int unsigned QUAL_CYCLES = us_to_cycles(CLK_HZ, 10),
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_low_a,
    output logic por_n
);
    logic       low_s;
    logic       hold_done;
    logic       qual_trip;
    srs_state_e state_q, state_d;
    logic       por_q;

    srs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(supply_low_a),
        .q_sync (low_s)
    );

    srs_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk (clk),
        .rst (rst),
        .run (state_q == ST_HOLD),
        .low (low_s),
        .done(hold_done)
    );

    srs_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk (clk),
        .rst (rst),
        .arm (state_q == ST_RUN),
        .low (low_s),
        .trip(qual_trip)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:  if (!low_s)        state_d = ST_HOLD;
            ST_HOLD: if (low_s)         state_d = ST_LOW;
                     else if (hold_done) state_d = ST_RUN;
            ST_RUN:  if (qual_trip)     state_d = ST_LOW;
            default:                    state_d = ST_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOW;
            por_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            por_q   <= (state_d == ST_RUN);
        end
    end

    assign por_n = por_q;
endmodule

// File: rtl/srs_check.sv
module srs_check import srs_pkg::*; #(
    parameter int unsigned QUAL_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       low_s,
    input srs_state_e state,
    input logic       por_n
);
    localparam int unsigned RW = cnt_width(QUAL_CYCLES + 1);
    localparam logic [RW-1:0] RMAX = RW'(QUAL_CYCLES + 1);

    logic [RW-1:0] low_run;
    logic          rst_d = 1'b0;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst || !low_s)      low_run <= '0;
        else if (low_run != RMAX) low_run <= low_run + 1'b1;
    end

    p_low_stays_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOW && low_s) |=> !por_n);

    p_rise_clear_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(por_n) |-> !$past(low_s));

    p_fall_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(por_n) |-> ($past(rst) || $past(low_s)));

    p_no_early_trip_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(por_n) && !$past(rst)) |-> (low_run >= RMAX));

    p_steady_high_r6: assert property (@(posedge clk) disable iff (rst)
        (por_n && !low_s) |=> por_n);

    p_hold_abort_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && low_s) |=> (state == ST_LOW));

    always_ff @(posedge clk) begin
        if (rst_d) begin
            p_reset_low_r9: assert (!por_n);
        end
    end
endmodule

bind supply_rst_seq srs_check #(.QUAL_CYCLES(QUAL_CYCLES)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .low_s(low_s),
    .state(state_q),
    .por_n(por_n)
);

// File: tb/sim_supply_rst_seq.sv
`timescale 1ns/1ps
module sim_supply_rst_seq;
    localparam int H = 20;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_low_a = 1'b1;
    logic por_n;
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;

    typedef struct {
        int    at;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb[$];

    supply_rst_seq #(.HOLD_CYCLES(H), .QUAL_CYCLES(Q), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .supply_low_a(supply_low_a), .por_n(por_n)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int off, input logic v, input string tag);
        exp_t e;
        e.at = cyc + off; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares at the falling edge of the cycle each item is due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (e.at < cyc) begin
                n_fail++;
                $display("FAIL %s missed slot cyc=%0d actual=%b expected=%b", e.tag, e.at, por_n, e.val);
            end else if (por_n !== e.val) begin
                n_fail++;
                $display("FAIL %s cyc=%0d actual=%b expected=%b", e.tag, cyc, por_n, e.val);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R9/R3: reset state
        step(1);
        expect_at(1, 1'b0, "R9 reset");
        step(3);
        rst = 1'b0;
        expect_at(5, 1'b0, "R3 low supply");
        expect_at(30, 1'b0, "R3 low supply");
        step(32);

        // R2: first power-up release
        supply_low_a = 1'b0;
        expect_at(H + 2, 1'b0, "R2 before release");
        expect_at(H + 3, 1'b1, "R2 release");
        step(H + 8);

        // R6: steady high
        expect_at(5, 1'b1, "R6 steady");
        expect_at(40, 1'b1, "R6 steady");
        step(42);

        // R5: dip of exactly Q cycles is ignored
        expect_at(2, 1'b1, "R5 short dip");
        expect_at(Q + 2, 1'b1, "R5 short dip");
        expect_at(Q + 3, 1'b1, "R5 short dip");
        expect_at(Q + 6, 1'b1, "R5 short dip");
        supply_low_a = 1'b1;
        step(Q);
        supply_low_a = 1'b0;
        step(12);

        // R8: two Q-cycle dips with a one-cycle gap do not add up
        expect_at(Q + 3, 1'b1, "R8 gap clears");
        expect_at(2 * Q + 4, 1'b1, "R8 gap clears");
        expect_at(2 * Q + 6, 1'b1, "R8 gap clears");
        supply_low_a = 1'b1;
        step(Q);
        supply_low_a = 1'b0;
        step(1);
        supply_low_a = 1'b1;
        step(Q);
        supply_low_a = 1'b0;
        step(12);

        // R4/R1: dip of Q+1 or more trips, then stays low
        expect_at(Q + 2, 1'b1, "R4 before trip");
        expect_at(Q + 3, 1'b0, "R4 trip");
        expect_at(Q + 20, 1'b0, "R1 held low");
        expect_at(Q + 60, 1'b0, "R1 held low");
        supply_low_a = 1'b1;
        step(Q + 62);

        // R7: drop during hold restarts the hold time
        expect_at(H + 3, 1'b0, "R7 hold aborted");
        expect_at(13 + H + 2, 1'b0, "R7 before release");
        expect_at(13 + H + 3, 1'b1, "R7 release");
        supply_low_a = 1'b0;
        step(10);
        supply_low_a = 1'b1;
        step(3);
        supply_low_a = 1'b0;
        step(H + 8);

        // R9: synchronous reset while released
        expect_at(1, 1'b0, "R9 forced low");
        expect_at(H + 3, 1'b0, "R9 restart hold");
        expect_at(H + 4, 1'b1, "R9 release");
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        step(H + 8);

        while (sb.size() > 0) step(1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule